// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache between a processor request port and a main-memory port. It holds eight one-word lines, organised as four sets of two ways. Replacement within a set is least-recently-used. Writes use a write-back, write-allocate policy. The processor presents an address, a read/write flag and write data with a request valid. A hit is answered in the same cycle. A miss holds ready low while the cache works with memory.

A miss picks a victim way. If that victim holds modified data, the victim word is first written to memory. The missing word is then read into the victim line. The access then completes from the cache array like any hit, so the processor always receives data from the cache. The memory side moves one word per transfer, with a request held until the memory acknowledges it.

Top module: `cache2w`

## Requirements
- R1: An address is decoded as a byte offset in bits 1:0, which is ignored, a set index in bits 3:2, and a tag in bits 31:4.
- R2: Reset clears every valid and dirty flag. After reset, `cpu_ready` is 1 and `mem_req` is 0 while no request is pending. The first access to any address after reset is a miss and writes nothing back.
- R3: While `cpu_valid` is 1, a read hit raises `cpu_ready` in the same cycle with `cpu_hit` = 1 and the cached word on `cpu_rdata`. A hit makes no memory transfer.
- R4: On a miss, `cpu_ready` stays 0 until the line is filled. Exactly one memory read is made, at the word address of the request. The access then completes with `cpu_hit` = 0 and the word from memory.
- R5: The victim on a miss is an invalid way if the set has one, and otherwise the least-recently-used way. Every hit and every fill marks the other way of the set as the next one to replace.
- R6: A dirty victim is written to memory, at the address formed from its own tag and index, before the refill read is issued. A clean victim causes no memory write.
- R7: A write hit updates the cached word and marks the line dirty, with no memory transfer.
- R8: A write miss first refills the line from memory, then merges the write data and marks the line dirty. No memory write is made for the stored word.
- R9: `mem_req` stays high with `mem_addr` and `mem_we` held stable until `mem_ack` is seen. A write-back is followed directly by the refill read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid; held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access completes this cycle (also 1 when idle) |
| cpu_rdata | output | 32 | Read data, valid with ready on a read |
| cpu_hit | output | 1 | With ready: 1 = served without a memory transfer |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | 32 | Refill data, valid with ack |

## Verification
The bench builds the cache with its default values: 32-bit addresses and data, and four sets. With this geometry, byte addresses 16 bytes apart fall into the same set. Three such addresses are enough to force the LRU choice, clean and dirty evictions, and refills of words that were written back earlier. The memory model answers each transfer after a short delay. This keeps the processor ready signal low over several cycles and lets the order of write-back and refill be recorded.

// File: rtl/cache2w.sv
module cache2w #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SETS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_hit,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int OW = 2;
  localparam int IW = $clog2(SETS);
  localparam int TW = AW - IW - OW;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL} st_t;
  st_t st;

  logic [TW-1:0]   tag_q  [2][SETS];
  logic [DW-1:0]   data_q [2][SETS];
  logic [SETS-1:0] vld_q  [2];
  logic [SETS-1:0] dty_q  [2];
  logic [SETS-1:0] lru_q;
  logic            vic_q;
  logic            miss_q;

  logic [IW-1:0] idx;
  logic [TW-1:0] tag;
  logic          hit0, hit1, hit_any, victim;
  logic          unused_off;

  assign idx        = cpu_addr[OW +: IW];
  assign tag        = cpu_addr[AW-1 -: TW];
  assign unused_off = &{1'b0, cpu_addr[OW-1:0]};

  assign hit0    = vld_q[0][idx] && (tag_q[0][idx] == tag);
  assign hit1    = vld_q[1][idx] && (tag_q[1][idx] == tag);
  assign hit_any = hit0 || hit1;
  assign victim  = !vld_q[0][idx] ? 1'b0 : (!vld_q[1][idx] ? 1'b1 : lru_q[idx]);

  assign cpu_ready = (st == S_IDLE) && (!cpu_valid || hit_any);
  assign cpu_rdata = hit1 ? data_q[1][idx] : data_q[0][idx];
  assign cpu_hit   = !miss_q;

  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_WB) ? {tag_q[vic_q][idx], idx, {OW{1'b0}}}
                                  : {cpu_addr[AW-1:OW], {OW{1'b0}}};
  assign mem_wdata = data_q[vic_q][idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      vld_q[0] <= '0;
      vld_q[1] <= '0;
      dty_q[0] <= '0;
      dty_q[1] <= '0;
      lru_q    <= '0;
      vic_q    <= 1'b0;
      miss_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cpu_valid) begin
          if (hit_any) begin
            lru_q[idx] <= ~hit1;
            if (cpu_we) dty_q[hit1][idx] <= 1'b1;
            miss_q <= 1'b0;
          end else begin
            vic_q  <= victim;
            miss_q <= 1'b1;
            st     <= (vld_q[victim][idx] && dty_q[victim][idx]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ack) st <= S_FILL;
        S_FILL: if (mem_ack) begin
          vld_q[vic_q][idx] <= 1'b1;
          dty_q[vic_q][idx] <= 1'b0;
          lru_q[idx]        <= ~vic_q;
          st                <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ack) begin
      tag_q[vic_q][idx]  <= tag;
      data_q[vic_q][idx] <= mem_rdata;
    end else if (st == S_IDLE && cpu_valid && hit_any && cpu_we) begin
      data_q[hit1][idx] <= cpu_wdata;
    end
  end
endmodule

module cache2w_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_valid,
  input logic          cpu_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_wb_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

  assert_busy_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  assert_fill_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> !mem_req && (cpu_ready || !cpu_valid));

  assert_idle_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid && !mem_req |-> cpu_ready);
endmodule

bind cache2w cache2w_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/sim_cache2w.sv
`timescale 1ns/1ps
module sim_cache2w;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, cpu_hit, mem_req, mem_we;
  logic [31:0] cpu_rdata, mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  cache2w u0 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, failures = 0;
  logic [31:0] mem [256];
  logic [31:0] exp_m [256];
  logic        log_we [1024];
  int wr_cnt = 0, rd_cnt = 0, op_cnt = 0, cnt = 0, hold_err = 0;
  logic [31:0] last_addr = '0;
  logic        last_we = 1'b0, pend = 1'b0;

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return 32'hA500_0000 ^ {a[31:2], 2'b00};
  endfunction

  initial for (int i = 0; i < 256; i++) begin
    mem[i]   = init_val(32'(i) << 2);
    exp_m[i] = init_val(32'(i) << 2);
  end

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (pend && mem_req && (mem_addr != last_addr || mem_we != last_we)) hold_err <= hold_err + 1;
    pend <= mem_req && !mem_ack;
    last_addr <= mem_addr;
    last_we <= mem_we;
    if (mem_req && !mem_ack) begin
      if (cnt == 1) begin
        mem_ack <= 1'b1;
        cnt <= 0;
        log_we[op_cnt] <= mem_we;
        op_cnt <= op_cnt + 1;
        if (mem_we) begin
          mem[mem_addr[9:2]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata <= mem[mem_addr[9:2]];
          rd_cnt <= rd_cnt + 1;
        end
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        output bit hit, output logic [31:0] rd, output int cyc,
                        output int nw, output int nr, output bit first_we);
    int w0, r0, o0;
    @(negedge clk);
    w0 = wr_cnt; r0 = rd_cnt; o0 = op_cnt;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0;
    #1;
    while (!cpu_ready && cyc < 100) begin
      @(negedge clk); #1; cyc++;
    end
    hit = cpu_hit; rd = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0; cpu_we = 1'b0;
    nw = wr_cnt - w0; nr = rd_cnt - r0;
    first_we = (op_cnt > o0) ? log_we[o0] : 1'b0;
    if (we) exp_m[a[9:2]] = d;
  endtask

  // {we, addr[7:0], data[7:0], exp_hit, exp_writeback}
  localparam logic [18:0] VEC [14] = '{
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b0},
    {1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
    {1'b1, 8'h10, 8'h11, 1'b0, 1'b0},
    {1'b0, 8'h10, 8'h00, 1'b1, 1'b0},
    {1'b0, 8'h20, 8'h00, 1'b0, 1'b0},
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b1},
    {1'b0, 8'h10, 8'h00, 1'b0, 1'b0},
    {1'b1, 8'h04, 8'h22, 1'b0, 1'b0},
    {1'b1, 8'h04, 8'h33, 1'b1, 1'b0},
    {1'b0, 8'h04, 8'h00, 1'b1, 1'b0},
    {1'b0, 8'h14, 8'h00, 1'b0, 1'b0},
    {1'b0, 8'h24, 8'h00, 1'b0, 1'b1},
    {1'b0, 8'h04, 8'h00, 1'b0, 1'b0},
    {1'b0, 8'h13, 8'h00, 1'b1, 1'b0}
  };

  bit done = 1'b0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit hit, fw;
    logic [31:0] rd;
    int cyc, nw, nr;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(cpu_ready == 1'b1 && mem_req == 1'b0, "R2 reset idle", {cpu_ready, mem_req}, 32'h2);

    for (int i = 0; i < 14; i++) begin
      logic [31:0] a, d;
      a = {24'h0, VEC[i][17:10]};
      d = {24'h0, VEC[i][9:2]};
      access(VEC[i][18], a, d, hit, rd, cyc, nw, nr, fw);
      chk(hit == VEC[i][1], $sformatf("R3/R5 hit row %0d", i), 32'(hit), 32'(VEC[i][1]));
      chk(nw == int'(VEC[i][0]), $sformatf("R6/R7/R8 writebacks row %0d", i), nw, 32'(VEC[i][0]));
      if (VEC[i][1]) begin
        chk(cyc == 0 && nr == 0, $sformatf("R3 same-cycle hit row %0d", i), cyc, 0);
      end else begin
        chk(cyc > 0 && nr == 1, $sformatf("R4 miss fill row %0d", i), nr, 1);
      end
      if (VEC[i][0]) chk(fw == 1'b1, $sformatf("R6 write-back first row %0d", i), 32'(fw), 1);
      if (!VEC[i][18])
        chk(rd == exp_m[a[9:2]], $sformatf("R1/R4 read data row %0d", i), rd, exp_m[a[9:2]]);
      if (i == 5) chk(mem[4] == 32'h11, "R6 victim word in memory", mem[4], 32'h11);
      if (i == 11) chk(mem[1] == 32'h33, "R6 second victim word", mem[1], 32'h33);
    end

    access(1'b1, 32'h0000_0008, 32'h44, hit, rd, cyc, nw, nr, fw);
    chk(hit == 1'b0 && nr == 1 && nw == 0, "R8 write miss allocates", {hit, 8'(nr), 8'(nw)}, 32'h100);
    chk(mem[2] == init_val(32'h8), "R8 write stays in cache", mem[2], init_val(32'h8));
    access(1'b0, 32'h0000_000A, 32'h0, hit, rd, cyc, nw, nr, fw);
    chk(hit && rd == 32'h44, "R7/R1 merged write readable", rd, 32'h44);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(cpu_ready == 1'b1 && mem_req == 1'b0, "R2 second reset idle", {cpu_ready, mem_req}, 32'h2);
    access(1'b0, 32'h0000_0008, 32'h0, hit, rd, cyc, nw, nr, fw);
    chk(hit == 1'b0 && nw == 0, "R2 dirty and valid cleared", {hit, 8'(nw)}, 32'h0);
    chk(rd == init_val(32'h8), "R2 refill after reset", rd, init_val(32'h8));

    chk(hold_err == 0, "R9 request held until ack", hold_err, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule